// File: doc/BRIEF.md
# Four-Port APB GPIO Register Bank

This block is a bus slave on an APB interface that controls up to four general-purpose I/O ports. Each port has three registers. A software data register holds the value to drive. A direction register decides, bit by bit, whether the pin is driven. A read-only sampled-pin register returns what the pad actually carries. The block drives the pad output value and the output-enable vectors directly. It passes every pad input through a two-stage synchroniser before software can see it.

The map is fixed. Each port's data/direction pair occupies a 12-byte slot. The four sampled-pin registers sit together in their own 4-byte-spaced group starting at 0x50. Each port has a width parameter, and bits above that width are held at zero. The synchronised port A inputs are also brought out on their own port, so that a neighbouring interrupt block can use them.

The reset input is asynchronous and active low. Inside the block it is released on a clock edge.

Top module: `apb_gpio_bank`

## Requirements
- R1: After reset, every data and direction register reads 0, and pad_out and pad_oe are all 0, so every pin starts as an input.
- R2: A write to byte offset 0x0C*p (p = 0..3 for ports A..D) loads port p's data register. Its value appears on pad_out[32p+31:32p] on the clock edge that ends the access phase, and it reads back at the same offset.
- R3: A write to byte offset 0x04+0x0C*p loads port p's direction register. pad_oe bit i of that port equals direction bit i, where 1 means output and 0 means input. The register reads back at the same offset.
- R4: A read of byte offset 0x50+4*p returns port p's pad input after two clock edges of synchronisation, whatever the direction setting.
- R5: Writes to the sampled-pin offsets and to unmapped offsets change no register.
- R6: Reads of unmapped offsets (for example 0x08, 0x2C, 0x4C, 0x60) return 0.
- R7: Bits at or above a port's width parameter read as 0 in every register of that port and are driven as 0 on pad_out and pad_oe.
- R8: pready is always 1 and pslverr is always 0.
- R9: port_a_sync carries port A's pad input delayed by two clock edges. It is the same value that the offset 0x50 read returns.
- R10: A register changes only on a write access phase (psel, penable and pwrite all high). A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address; bits 1:0 ignored |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid while psel is high and pwrite is low |
| pready | output | 1 | Tied high |
| pslverr | output | 1 | Tied low |
| pad_in | input | 128 | Pad inputs, port p at bits 32p+31:32p |
| pad_out | output | 128 | Pad output values |
| pad_oe | output | 128 | Pad output enables |
| port_a_sync | output | 32 | Synchronised port A inputs for the interrupt block |

## Verification
The assertions check on every cycle that the bus never stalls or errors and that pad outputs hold still when there is no write access phase. They also check that port A's data and direction writes reach the pads one edge later, that the port A synchroniser output lags the pad by exactly two edges, and that the gap at 0x08 reads zero. The bench scenarios are needed to show the full address map for all four ports, the upper-bit masking of a narrowed port, and that writes to sampled-pin and unmapped offsets leave the stored values unchanged. They also show that a pin configured as an output still reports its pad value.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int MAX_PORTS  = 4;
  localparam int REG_W      = 32;
  // word indices (byte offset / 4)
  localparam int SLOT_WORDS = 3;   // data/direction slot stride
  localparam int DIR_WORD   = 1;   // direction inside the slot
  localparam int PIN_WORD0  = 20;  // first sampled-pin register (0x50)

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_DATA = 2'd1,
    ACC_DIR  = 2'd2,
    ACC_PIN  = 2'd3
  } acc_kind_e;

  typedef struct packed {
    acc_kind_e  kind;
    logic [1:0] port;
  } acc_t;

  function automatic logic [REG_W-1:0] width_mask(input int w);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < w);
    return m;
  endfunction

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_t              acc
);

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [1:0]        unused_lsb;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lsb = addr[1:0];

  always_comb begin
    acc.kind = ACC_NONE;
    acc.port = 2'd0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (word == WORD_W'(p * SLOT_WORDS)) begin
        acc.kind = ACC_DATA;
        acc.port = 2'(p);
      end
      if (word == WORD_W'(p * SLOT_WORDS + DIR_WORD)) begin
        acc.kind = ACC_DIR;
        acc.port = 2'(p);
      end
      if (word == WORD_W'(PIN_WORD0 + p)) begin
        acc.kind = ACC_PIN;
        acc.port = 2'(p);
      end
    end
  end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_we,
  input  logic             dir_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] pad_i,
  output logic [REG_W-1:0] data_q,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] pin_q
);

  localparam logic [REG_W-1:0] MASK = width_mask(WIDTH);

  logic [REG_W-1:0] data_d, dir_d, meta_q, meta_d, pin_d;

  // next-state
  always_comb begin
    data_d = data_q;
    dir_d  = dir_q;
    if (data_we) data_d = wdata & MASK;
    if (dir_we)  dir_d  = wdata & MASK;
    meta_d = pad_i & MASK;
    pin_d  = meta_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      meta_q <= '0;
      pin_q  <= '0;
    end else begin
      if (data_we) data_q <= data_d;
      if (dir_we)  dir_q  <= dir_d;
      meta_q <= meta_d;
      pin_q  <= pin_d;
    end
  end

endmodule

// File: rtl/apb_gpio_bank.sv
module apb_gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int WIDTH_A   = 32,
  parameter int WIDTH_B   = 32,
  parameter int WIDTH_C   = 32,
  parameter int WIDTH_D   = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                         pclk,
  input  logic                         presetn,
  input  logic                         psel,
  input  logic                         penable,
  input  logic                         pwrite,
  input  logic [ADDR_W-1:0]            paddr,
  input  logic [31:0]                  pwdata,
  output logic [31:0]                  prdata,
  output logic                         pready,
  output logic                         pslverr,
  input  logic [MAX_PORTS*REG_W-1:0]   pad_in,
  output logic [MAX_PORTS*REG_W-1:0]   pad_out,
  output logic [MAX_PORTS*REG_W-1:0]   pad_oe,
  output logic [31:0]                  port_a_sync
);

  function automatic int port_width(input int p);
    case (p)
      0:       return WIDTH_A;
      1:       return WIDTH_B;
      2:       return WIDTH_C;
      default: return WIDTH_D;
    endcase
  endfunction

  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta, rst_q;
  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  acc_t acc;
  gpio_addr_dec #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
    .addr (paddr),
    .acc  (acc)
  );

  logic wr_fire, rd_sel;
  assign wr_fire = psel & penable & pwrite;
  assign rd_sel  = psel & ~pwrite;

  logic [REG_W-1:0] data_v [MAX_PORTS];
  logic [REG_W-1:0] dir_v  [MAX_PORTS];
  logic [REG_W-1:0] pin_v  [MAX_PORTS];

  for (genvar p = 0; p < MAX_PORTS; p++) begin : g_port
    if (p < NUM_PORTS) begin : g_on
      logic data_we, dir_we;
      assign data_we = wr_fire && (acc.kind == ACC_DATA) && (acc.port == 2'(p));
      assign dir_we  = wr_fire && (acc.kind == ACC_DIR)  && (acc.port == 2'(p));
      gpio_port_regs #(.WIDTH(port_width(p))) u_regs (
        .clk     (pclk),
        .rst_n   (rst_q),
        .data_we (data_we),
        .dir_we  (dir_we),
        .wdata   (pwdata),
        .pad_i   (pad_in[p*REG_W +: REG_W]),
        .data_q  (data_v[p]),
        .dir_q   (dir_v[p]),
        .pin_q   (pin_v[p])
      );
    end else begin : g_off
      logic [REG_W-1:0] unused_pad;
      assign unused_pad = pad_in[p*REG_W +: REG_W];
      assign data_v[p]  = '0;
      assign dir_v[p]   = '0;
      assign pin_v[p]   = '0;
    end
    assign pad_out[p*REG_W +: REG_W] = data_v[p];
    assign pad_oe [p*REG_W +: REG_W] = dir_v[p];
  end

  // read-back mux
  always_comb begin
    prdata = '0;
    if (rd_sel) begin
      case (acc.kind)
        ACC_DATA: prdata = data_v[acc.port];
        ACC_DIR:  prdata = dir_v[acc.port];
        ACC_PIN:  prdata = pin_v[acc.port];
        default:  prdata = '0;
      endcase
    end
  end

  assign pready      = 1'b1;
  assign pslverr     = 1'b0;
  assign port_a_sync = pin_v[0];

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int WIDTH_A = 32
) (
  input logic                       pclk,
  input logic                       rst_n,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic [ADDR_W-1:0]          paddr,
  input logic [31:0]                pwdata,
  input logic [31:0]                prdata,
  input logic                       pready,
  input logic                       pslverr,
  input logic [31:0]                pad_in_a,
  input logic [MAX_PORTS*REG_W-1:0] pad_out,
  input logic [MAX_PORTS*REG_W-1:0] pad_oe,
  input logic [31:0]                port_a_sync
);

  localparam logic [31:0] MASK_A = width_mask(WIDTH_A);

  logic [1:0] cyc;
  always_ff @(posedge pclk or negedge rst_n) begin
    if (!rst_n)         cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  logic wr;
  assign wr = psel && penable && pwrite;

  AST_RESET_IDLE: assert property (@(posedge pclk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0) && (pad_out == '0));  // R1

  AST_DATA_A_WRITE: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(8'h00)) |=> pad_out[31:0] == ($past(pwdata) & MASK_A));  // R2

  AST_DIR_A_WRITE: assert property (@(posedge pclk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(8'h04)) |=> pad_oe[31:0] == ($past(pwdata) & MASK_A));  // R3

  AST_SYNC_LATENCY: assert property (@(posedge pclk) disable iff (!rst_n)
    (cyc >= 2'd2) |-> port_a_sync == ($past(pad_in_a, 2) & MASK_A));  // R9

  AST_GAP_READS_ZERO: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && !pwrite && paddr == ADDR_W'(8'h08)) |-> prdata == 32'd0);  // R6

  AST_NO_WAIT: assert property (@(posedge pclk) disable iff (!rst_n)
    pready && !pslverr);  // R8

  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge pclk) disable iff (!rst_n)
    !wr |=> $stable(pad_out) && $stable(pad_oe));  // R10

endmodule

bind apb_gpio_bank gpio_bank_chk #(.ADDR_W(ADDR_W), .WIDTH_A(WIDTH_A)) u_chk (
  .pclk        (pclk),
  .rst_n       (rst_q),
  .psel        (psel),
  .penable     (penable),
  .pwrite      (pwrite),
  .paddr       (paddr),
  .pwdata      (pwdata),
  .prdata      (prdata),
  .pready      (pready),
  .pslverr     (pslverr),
  .pad_in_a    (pad_in[31:0]),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .port_a_sync (port_a_sync)
);

// File: tb/tb_apb_gpio_bank.sv
module tb_apb_gpio_bank;

  localparam int AW = 8;
  localparam int NV = 34;

  logic          pclk = 1'b0;
  logic          presetn;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0]   pwdata, prdata;
  logic          pready, pslverr;
  logic [127:0]  pad_in, pad_out, pad_oe;
  logic [31:0]   port_a_sync;

  int checks = 0;
  int errors = 0;

  always #4 pclk = ~pclk;  // 125 MHz

  apb_gpio_bank #(.WIDTH_D(12), .ADDR_W(AW)) dut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .port_a_sync(port_a_sync)
  );

  // {write, addr, wdata, expected read}
  localparam logic [72:0] VEC [NV] = '{
    {1'b1, 8'h00, 32'hA5A5_0F0F, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'hA5A5_0F0F},          // R2
    {1'b1, 8'h04, 32'hFFFF_0000, 32'h0},
    {1'b0, 8'h04, 32'h0, 32'hFFFF_0000},          // R3
    {1'b1, 8'h0C, 32'h1234_5678, 32'h0},
    {1'b0, 8'h0C, 32'h0, 32'h1234_5678},          // R2
    {1'b1, 8'h10, 32'h0000_00FF, 32'h0},
    {1'b0, 8'h10, 32'h0, 32'h0000_00FF},          // R3
    {1'b1, 8'h18, 32'hCAFE_F00D, 32'h0},
    {1'b0, 8'h18, 32'h0, 32'hCAFE_F00D},          // R2
    {1'b1, 8'h1C, 32'h8000_0001, 32'h0},
    {1'b0, 8'h1C, 32'h0, 32'h8000_0001},          // R3
    {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h24, 32'h0, 32'h0000_0FFF},          // R7
    {1'b1, 8'h28, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 8'h28, 32'h0, 32'h0000_0FFF},          // R7
    {1'b1, 8'h08, 32'hDEAD_BEEF, 32'h0},
    {1'b0, 8'h08, 32'h0, 32'h0},                  // R5 R6
    {1'b1, 8'h50, 32'h1111_1111, 32'h0},
    {1'b1, 8'h2C, 32'h2222_2222, 32'h0},
    {1'b1, 8'h60, 32'h3333_3333, 32'h0},
    {1'b0, 8'h00, 32'h0, 32'hA5A5_0F0F},          // R5
    {1'b0, 8'h04, 32'h0, 32'hFFFF_0000},          // R5
    {1'b0, 8'h0C, 32'h0, 32'h1234_5678},          // R5
    {1'b0, 8'h10, 32'h0, 32'h0000_00FF},          // R5
    {1'b0, 8'h18, 32'h0, 32'hCAFE_F00D},          // R5
    {1'b0, 8'h1C, 32'h0, 32'h8000_0001},          // R5
    {1'b0, 8'h24, 32'h0, 32'h0000_0FFF},          // R5
    {1'b0, 8'h28, 32'h0, 32'h0000_0FFF},          // R5
    {1'b0, 8'h50, 32'h0, 32'h0},                  // R4
    {1'b0, 8'h2C, 32'h0, 32'h0},                  // R6
    {1'b0, 8'h4C, 32'h0, 32'h0},                  // R6
    {1'b0, 8'h60, 32'h0, 32'h0},                  // R6
    {1'b0, 8'h14, 32'h0, 32'h0}                   // R6
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errors);
    $finish;
  endtask

  // call at a negedge; consumes two clock edges
  task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  // call at a negedge; consumes no clock edge
  task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    #1 d = prdata;
    psel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge pclk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    logic [31:0] r;
    presetn = 1'b0; psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    paddr = '0; pwdata = '0; pad_in = '0;
    repeat (4) @(posedge pclk);
    @(negedge pclk);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);

    // reset state
    check("R1 pad_oe", pad_oe[31:0] | pad_oe[63:32] | pad_oe[95:64] | pad_oe[127:96], 32'h0);
    check("R1 pad_out", pad_out[31:0] | pad_out[63:32] | pad_out[95:64] | pad_out[127:96], 32'h0);
    apb_rd(8'h04, r); check("R1 dir A", r, 32'h0);
    apb_rd(8'h24, r); check("R1 data D", r, 32'h0);
    check("R8 bus handshake", {30'd0, pready, pslverr}, 32'h2);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][72]) apb_wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        apb_rd(VEC[i][71:64], r);
        check($sformatf("R2/R3/R5/R6/R7 vector %0d", i), r, VEC[i][31:0]);
        @(negedge pclk);
      end
    end

    // pad side after table
    check("R2 pad_out A", pad_out[31:0], 32'hA5A5_0F0F);
    check("R3 pad_oe A", pad_oe[31:0], 32'hFFFF_0000);
    check("R2 pad_out C", pad_out[95:64], 32'hCAFE_F00D);
    check("R7 pad_out D", pad_out[127:96], 32'h0000_0FFF);
    check("R7 pad_oe D", pad_oe[127:96], 32'h0000_0FFF);

    // setup phase alone is not a write
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 8'h00; pwdata = 32'h0;
    @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge pclk);
    check("R10 setup only", pad_out[31:0], 32'hA5A5_0F0F);

    // synchroniser latency on port B
    pad_in[63:32] = 32'h5A5A_1234;
    @(negedge pclk);
    apb_rd(8'h54, r); check("R4 one edge", r, 32'h0);
    @(negedge pclk);
    apb_rd(8'h54, r); check("R4 two edges", r, 32'h5A5A_1234);

    // output pins still report pad value; port A sync side port
    pad_in[31:0] = 32'hFFFF_FFFF;
    pad_in[127:96] = 32'hFFFF_FFFF;
    repeat (2) @(negedge pclk);
    apb_rd(8'h50, r); check("R4 output pin read", r, 32'hFFFF_FFFF);
    check("R9 port_a_sync", port_a_sync, 32'hFFFF_FFFF);
    apb_rd(8'h5C, r); check("R7 pins D", r, 32'h0000_0FFF);

    // write to sampled-pin register ignored
    apb_wr(8'h50, 32'h0);
    apb_rd(8'h50, r); check("R5 pin write", r, 32'hFFFF_FFFF);
    check("R5 pad_out A kept", pad_out[31:0], 32'hA5A5_0F0F);

    // reset mid-run
    presetn = 1'b0;
    @(negedge pclk);
    check("R1 async clear", pad_oe[31:0], 32'h0);
    presetn = 1'b1;
    repeat (3) @(negedge pclk);
    apb_rd(8'h00, r); check("R1 data A after reset", r, 32'h0);

    finish_up();
  end

endmodule